// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block decides when a double-data-rate SDRAM must be refreshed and asks a command arbiter to issue the refreshes. A free-running interval timer adds one owed refresh on every average-interval boundary. Owed refreshes are kept in a small backlog, so the arbiter may postpone them while it serves traffic and pay them back later in a tight burst. The backlog cannot grow past eight. When it is full, an urgent flag tells the arbiter to stop opening rows until a refresh has been granted. Consecutive refreshes are kept apart by the refresh row cycle time. A refresh grant is taken only while the arbiter reports every bank precharged.

The block also drives the clock-enable level for self refresh. An entry request, accepted while the banks are idle, lowers clock-enable. While clock-enable is low the device refreshes itself, so the backlog is cleared and the interval timer rests. An exit request raises clock-enable again. Two recovery windows then start: one gates non-read commands and a longer one gates reads. The interval timer restarts from zero at exit.

Intervals are set in picoseconds and converted to clock cycles from the clock period parameter. The refresh interval is rounded down so that the average is never longer than allowed. The recovery and spacing times are rounded up.

Top module: `rfsh_scheduler`

## Requirements
- R1: After reset, ref_req, ref_urgent and pending are 0, and cke, nonread_ok and read_ok are 1.
- R2: While cke is high, pending rises by one every INT_CYC cycles, where INT_CYC = floor(TREFI_PS/CLK_PS). The first increment is seen INT_CYC cycles after the first clock edge with reset released.
- R3: pending saturates at MAX_PEND (8), and interval boundaries that arrive when it is full are lost. ref_urgent is 1 exactly when pending equals MAX_PEND.
- R4: ref_req is 1 when cke is high, pending is non-zero, the refresh spacing has elapsed and the non-read recovery has elapsed. A grant is accepted when ref_gnt, ref_req and banks_idle are all 1, and it lowers pending by one in the next cycle. An accepted grant in the same cycle as an interval boundary leaves pending unchanged.
- R5: ref_gnt is ignored when banks_idle is 0 or ref_req is 0. Such a grant does not lower pending and does not restart the spacing.
- R6: After an accepted grant, ref_req stays 0 for TRFC_CYC-1 cycles, where TRFC_CYC = ceil(TRFC_PS/CLK_PS). The next grant can therefore come no sooner than TRFC_CYC cycles later.
- R7: sr_enter_req is accepted when cke is high, banks_idle is 1, the spacing and non-read recovery have elapsed, and no grant is accepted in the same cycle. cke falls in the next cycle and pending becomes 0. The request has no effect while banks_idle is 0.
- R8: While cke is low, ref_req, nonread_ok and read_ok are 0, and pending stays 0.
- R9: sr_exit_req while cke is low raises cke in the next cycle. nonread_ok rises XSNR_CYC = ceil(XSNR_PS/CLK_PS) cycles after cke rises, and read_ok rises XSRD_CYC cycles after cke rises. ref_req stays 0 until nonread_ok is 1.
- R10: After self-refresh exit, the first pending increment is seen INT_CYC cycles after cke rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | All banks are precharged |
| ref_gnt | input | 1 | Arbiter grants the pending refresh |
| sr_enter_req | input | 1 | Request to enter self refresh |
| sr_exit_req | input | 1 | Request to leave self refresh |
| ref_req | output | 1 | A refresh is owed and may be issued now |
| ref_urgent | output | 1 | Backlog full; refresh before any new activate |
| pending | output | $clog2(MAX_PEND+1) | Number of owed refreshes |
| cke | output | 1 | Clock-enable level for the device |
| nonread_ok | output | 1 | Non-read commands allowed |
| read_ok | output | 1 | Read commands allowed |

## Verification
The assertions assume the arbiter keeps its side of the handshake. A refresh counts as granted only when it is both requested and reported idle, and an entry request leads to a falling clock-enable only when banks_idle was high in the previous cycle. The bench drives grants, idle reports and self-refresh requests in fixed phases: a long idle run to fill the backlog, grants offered while the banks are busy, a drain that grants back-to-back, and entry and exit sequences. It also drives some inputs that must be ignored, such as grants while busy and entry requests while banks are open. Every phase keeps the inputs stable across each rising edge, and sr_exit_req is raised only while cke is low.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;
    typedef enum logic {
        MODE_AWAKE  = 1'b0,
        MODE_SLEEP  = 1'b1
    } rfsh_mode_e;

    typedef struct packed {
        rfsh_mode_e mode;
    } sched_state_t;
endpackage

// File: rtl/rfsh_interval_timer.sv
`timescale 1ns/1ps
module rfsh_interval_timer #(
    parameter int INT_CYC = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(INT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(INT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == LAST);
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rfsh_backlog.sv
`timescale 1ns/1ps
module rfsh_backlog #(
    parameter int MAX_PEND = 8,
    parameter int PW       = $clog2(MAX_PEND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    output logic [PW-1:0] count,
    output logic          full
);
    localparam logic [PW-1:0] CAP = PW'(MAX_PEND);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } blog_t;

    blog_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && !dec) begin
            if (st_q.cnt != CAP) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (dec && !inc) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CAP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rfsh_hold_timer.sv
`timescale 1ns/1ps
module rfsh_hold_timer #(
    parameter int LOAD = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int HW = $clog2(LOAD + 2);
    localparam logic [HW-1:0] LVAL = HW'(LOAD);

    typedef struct packed {
        logic [HW-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = LVAL;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    assign done = (st_q.cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rfsh_scheduler.sv
`timescale 1ns/1ps
module rfsh_scheduler
    import rfsh_pkg::*;
#(
    parameter int CLK_PS   = 7500,
    parameter int TREFI_PS = 7800000,
    parameter int TRFC_PS  = 75000,
    parameter int XSNR_PS  = 75000,
    parameter int XSRD_CYC = 200,
    parameter int MAX_PEND = 8,
    parameter int PW       = $clog2(MAX_PEND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          banks_idle,
    input  logic          ref_gnt,
    input  logic          sr_enter_req,
    input  logic          sr_exit_req,
    output logic          ref_req,
    output logic          ref_urgent,
    output logic [PW-1:0] pending,
    output logic          cke,
    output logic          nonread_ok,
    output logic          read_ok
);
    localparam int INT_CYC  = TREFI_PS / CLK_PS;
    localparam int TRFC_CYC = (TRFC_PS + CLK_PS - 1) / CLK_PS;
    localparam int XSNR_CYC = (XSNR_PS + CLK_PS - 1) / CLK_PS;

    sched_state_t st_d, st_q;

    logic       awake;
    logic       tick;
    logic       full;
    logic       gap_done;
    logic [1:0] exit_done;
    logic       grant_acc;
    logic       enter_acc;
    logic       exit_acc;

    rfsh_interval_timer #(
        .INT_CYC (INT_CYC)
    ) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (awake),
        .tick  (tick)
    );

    rfsh_backlog #(
        .MAX_PEND (MAX_PEND),
        .PW       (PW)
    ) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (grant_acc),
        .clr   (enter_acc),
        .count (pending),
        .full  (full)
    );

    rfsh_hold_timer #(
        .LOAD (TRFC_CYC - 1)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (grant_acc),
        .done  (gap_done)
    );

    // index 0: non-read recovery, index 1: read recovery
    for (genvar g = 0; g < 2; g++) begin : g_exit
        rfsh_hold_timer #(
            .LOAD ((g == 0) ? XSNR_CYC : XSRD_CYC)
        ) u_rec (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (exit_acc),
            .done  (exit_done[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        awake     = (st_q.mode == MODE_AWAKE);
        ref_req   = awake && (pending != '0) && gap_done && exit_done[0];
        grant_acc = ref_req && ref_gnt && banks_idle;
        enter_acc = awake && sr_enter_req && banks_idle && gap_done
                    && exit_done[0] && !grant_acc;
        exit_acc  = !awake && sr_exit_req;
        if (enter_acc) begin
            st_d.mode = MODE_SLEEP;
        end else if (exit_acc) begin
            st_d.mode = MODE_AWAKE;
        end
    end

    assign cke        = awake;
    assign ref_urgent = full;
    assign nonread_ok = awake && exit_done[0];
    assign read_ok    = awake && exit_done[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_AWAKE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rfsh_scheduler_chk.sv
`timescale 1ns/1ps
module rfsh_scheduler_chk #(
    parameter int MAX_PEND = 8,
    parameter int TRFC_CYC = 10,
    parameter int PW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          banks_idle,
    input logic          ref_gnt,
    input logic          ref_req,
    input logic          ref_urgent,
    input logic [PW-1:0] pending,
    input logic          cke,
    input logic          nonread_ok,
    input logic          read_ok
);
    int  since_q;
    logic took;

    assign took = ref_req && ref_gnt && banks_idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= TRFC_CYC;
        end else if (took) begin
            since_q <= 1;
        end else if (since_q < TRFC_CYC) begin
            since_q <= since_q + 1;
        end
    end

    AST_URGENT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> int'(pending) == MAX_PEND); // R3
    AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && $past(cke)) |-> (int'(pending) == int'($past(pending))
            || int'(pending) == int'($past(pending)) + 1
            || int'(pending) + 1 == int'($past(pending)))); // R2
    AST_BUSY_GNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt && !banks_idle) |=> int'(pending) >= int'($past(pending))); // R5
    AST_REFRESH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        took |-> since_q >= TRFC_CYC); // R6
    AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(banks_idle)); // R7
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (!ref_req && !nonread_ok && !read_ok)); // R8
    AST_EXIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (!nonread_ok && !read_ok)); // R9
    AST_REQ_AFTER_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> nonread_ok); // R9
endmodule

bind rfsh_scheduler rfsh_scheduler_chk #(
    .MAX_PEND (MAX_PEND),
    .TRFC_CYC (TRFC_CYC),
    .PW       (PW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .banks_idle (banks_idle),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .pending    (pending),
    .cke        (cke),
    .nonread_ok (nonread_ok),
    .read_ok    (read_ok)
);

// File: tb/rfsh_scheduler_tb_top.sv
`timescale 1ns/1ps
module rfsh_scheduler_tb_top;
    localparam int CLK_PS = 5000;
    localparam int T_INT  = 7800000 / CLK_PS;
    localparam int T_RFC  = (75000 + CLK_PS - 1) / CLK_PS;
    localparam int T_XSNR = (75000 + CLK_PS - 1) / CLK_PS;
    localparam int T_XSRD = 200;
    localparam int CAPN   = 8;
    localparam int PW     = $clog2(CAPN + 1);
    localparam int BIG    = 1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic banks_idle = 1'b0, ref_gnt = 1'b0, sr_enter_req = 1'b0, sr_exit_req = 1'b0;
    logic ref_req, ref_urgent, cke, nonread_ok, read_ok;
    logic [PW-1:0] pending;

    always #2.5 clk = ~clk;

    rfsh_scheduler #(
        .CLK_PS   (CLK_PS),
        .TREFI_PS (7800000),
        .TRFC_PS  (75000),
        .XSNR_PS  (75000),
        .XSRD_CYC (T_XSRD),
        .MAX_PEND (CAPN),
        .PW       (PW)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .banks_idle   (banks_idle),
        .ref_gnt      (ref_gnt),
        .sr_enter_req (sr_enter_req),
        .sr_exit_req  (sr_exit_req),
        .ref_req      (ref_req),
        .ref_urgent   (ref_urgent),
        .pending      (pending),
        .cke          (cke),
        .nonread_ok   (nonread_ok),
        .read_ok      (read_ok)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference: owed refreshes, time since events
    int m_pend = 0;
    int m_phase = 0;
    int m_since_gnt = BIG;
    int m_since_exit = BIG;
    bit m_sleep = 0;

    function automatic bit m_req();
        return !m_sleep && m_pend > 0 && m_since_gnt >= T_RFC && m_since_exit >= T_XSNR;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge(input bit g, input bit idle, input bit en, input bit ex);
        bit acc, enter, leave, tick;
        acc   = m_req() && g && idle;
        enter = !m_sleep && en && idle && m_since_gnt >= T_RFC
                && m_since_exit >= T_XSNR && !acc;
        leave = m_sleep && ex;
        tick  = !m_sleep && (m_phase == T_INT - 1);
        m_since_gnt  = acc ? 1 : (m_since_gnt < BIG ? m_since_gnt + 1 : BIG);
        m_since_exit = leave ? 0 : (m_since_exit < BIG ? m_since_exit + 1 : BIG);
        if (enter) begin
            m_sleep = 1; m_pend = 0; m_phase = 0;
        end else if (leave) begin
            m_sleep = 0; m_phase = 0;
        end else if (!m_sleep) begin
            m_phase = tick ? 0 : m_phase + 1;
            m_pend  = m_pend + (tick ? 1 : 0) - (acc ? 1 : 0);
            if (m_pend > CAPN) m_pend = CAPN;
        end
    endtask

    task automatic step(input bit g, input bit idle, input bit en, input bit ex);
        ref_gnt = g; banks_idle = idle; sr_enter_req = en; sr_exit_req = ex;
        @(negedge clk);
        model_edge(g, idle, en, ex);
        chk("R4 R6 ref_req", int'(ref_req), int'(m_req()));
        chk("R3 ref_urgent", int'(ref_urgent), int'(m_pend == CAPN));
        chk("R2 R4 pending", int'(pending), m_pend);
        chk("R7 R8 cke", int'(cke), int'(!m_sleep));
        chk("R9 nonread_ok", int'(nonread_ok), int'(!m_sleep && m_since_exit >= T_XSNR));
        chk("R9 read_ok", int'(read_ok), int'(!m_sleep && m_since_exit >= T_XSRD));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int last_req;
        int cyc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        banks_idle = 1'b1;
        // R1 reset state
        chk("R1 ref_req", int'(ref_req), 0);
        chk("R1 ref_urgent", int'(ref_urgent), 0);
        chk("R1 pending", int'(pending), 0);
        chk("R1 cke", int'(cke), 1);
        chk("R1 nonread_ok", int'(nonread_ok), 1);
        chk("R1 read_ok", int'(read_ok), 1);

        // R2 first increment at exactly T_INT cycles
        for (int i = 0; i < T_INT - 1; i++) step(0, 1, 0, 0);
        chk("R2 before first boundary", int'(pending), 0);
        step(0, 1, 0, 0);
        chk("R2 first boundary", int'(pending), 1);

        // R3 fill the backlog past its cap
        for (int i = 0; i < 9 * T_INT; i++) step(0, 1, 0, 0);
        chk("R3 saturated", int'(pending), CAPN);
        chk("R3 urgent", int'(ref_urgent), 1);

        // R5 grants while banks are busy are ignored
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0);
        chk("R5 busy grant ignored", int'(pending), CAPN);

        // R7 entry blocked while banks are open
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0);
        chk("R7 entry blocked", int'(cke), 1);

        // align to just after a boundary, then drain back-to-back
        while (m_phase != 0) step(0, 1, 0, 0);
        last_req = -1;
        cyc = 0;
        for (int i = 0; i < CAPN * T_RFC; i++) begin
            if (ref_req) begin
                if (last_req >= 0) chk("R6 spacing", cyc - last_req, T_RFC);
                last_req = cyc;
            end
            step(1, 1, 0, 0);
            cyc++;
        end
        chk("R4 drained", int'(pending), 0);
        chk("R3 urgent cleared", int'(ref_urgent), 0);

        // R4 grant in the same cycle as a boundary cancels out
        while (m_pend != 1) step(0, 1, 0, 0);
        while (m_phase != T_INT - 1) step(0, 1, 0, 0);
        step(1, 1, 0, 0);
        chk("R4 tick and grant cancel", int'(pending), 1);

        // R7 entry clears the backlog
        for (int i = 0; i < 3 * T_INT; i++) step(0, 1, 0, 0);
        step(0, 1, 1, 0);
        chk("R7 cke low", int'(cke), 0);
        chk("R7 pending cleared", int'(pending), 0);

        // R8 nothing accumulates while asleep
        for (int i = 0; i < 2 * T_INT + 50; i++) step(0, 1, 0, 0);
        chk("R8 pending asleep", int'(pending), 0);
        chk("R8 no req asleep", int'(ref_req), 0);

        // R9 exit and recovery windows
        step(0, 1, 0, 1);
        chk("R9 cke raised", int'(cke), 1);
        chk("R9 nonread held", int'(nonread_ok), 0);
        for (int i = 1; i < T_INT; i++) begin
            step(0, 1, 0, 0);
            if (i == T_XSNR - 1) chk("R9 nonread before", int'(nonread_ok), 0);
            if (i == T_XSNR)     chk("R9 nonread at", int'(nonread_ok), 1);
            if (i == T_XSRD - 1) chk("R9 read before", int'(read_ok), 0);
            if (i == T_XSRD)     chk("R9 read at", int'(read_ok), 1);
        end
        // R10 interval restarted at exit
        chk("R10 before boundary", int'(pending), 0);
        step(0, 1, 0, 0);
        chk("R10 boundary after exit", int'(pending), 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule